// File: doc/BRIEF.md
# Memory-Mapped Field Register Bank

This block is a small bank of control and status fields behind a simple word-addressed bus. The bus carries 32-bit data and has one word per address. A host drives an address, write data, and a write or read strobe. For a read, the data comes back one clock later together with a valid flag. Toward the fabric, every stored field is presented in parallel at all times. Status values are sampled straight from fabric inputs. For each mapped address, a one-cycle pulse reports that the address was read or written.

Each address has exactly one access behaviour: read/write, read-only, write-only, clear-on-read, or strobe-on-write. The bank holds six fields:

- Address 0: a 32-bit read/write control word with a reset value of 0x0000_0001.
- Address 1: a signed 12-bit read-only status, returned sign-extended.
- Address 2: a 16-bit event counter that is cleared by the read that returns it.
- Address 3: a write-only command word. Each write raises a one-cycle strobe and drives the written data on a parallel output.
- Addresses 4 and 5: a 64-bit read-only count. Reading its low word at address 4 freezes the upper half, so a following read of address 5 returns a value consistent with that low word.

Top module: `mmr_field_regs`

## Requirements
- R1: After reset, `ctrl_out` is 0x0000_0001, `cmd_pulse` and `bus_rvalid` are 0, the event counter (address 2) reads 0, and the frozen high word (address 5) reads 0.
- R2: `bus_rvalid` is high in exactly the cycle after a cycle with `bus_rd` high, and low otherwise. `bus_rdata` holds the read word in that cycle.
- R3: A write to address 0 updates `ctrl_out` on the next clock, and a read of address 0 returns the stored word.
- R4: A read of address 1 returns `stat_in` sampled in the strobe cycle, with bit 11 copied into bits 31..12.
- R5: Writes to addresses 1, 2, 4, 5, 6 and 7 change no state: `ctrl_out`, the event counter and the frozen high word keep their values, and no write pulse fires.
- R6: A read of address 3, 6 or 7 returns 0.
- R7: The event counter at address 2 adds one for each clock edge with `evt_in` high. A read returns the count zero-extended to 32 bits and clears the counter.
- R8: If `evt_in` is high in the same cycle as a clearing read of address 2, that read returns the old count and the counter becomes 1.
- R9: A write to address 3 makes `cmd_pulse` high for exactly the next cycle, with `cmd_data` equal to the written word. `cmd_pulse` is low in every other cycle.
- R10: A read of address 4 returns `wide_cnt_in[31:0]` and latches `wide_cnt_in[63:32]` in the same cycle. A read of address 5 returns that latched value, no matter how `wide_cnt_in` has changed since.
- R11: Bit a of `addr_rd_pulse` (a from 0 to 5) is high in the cycle after a read of address a, if that address is readable (0, 1, 2, 4, 5). Bit a of `addr_wr_pulse` is high in the cycle after a write of address a, if that address is writable (0, 3). Both vectors are zero in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ctrl_out | output | 32 | Control field, always driven |
| stat_in | input | 12 | Signed status from the fabric |
| evt_in | input | 1 | Event increment request |
| cmd_pulse | output | 1 | One-cycle command strobe |
| cmd_data | output | 32 | Last written command word |
| wide_cnt_in | input | 64 | 64-bit count from the fabric |
| addr_rd_pulse | output | 6 | Per-address read pulses |
| addr_wr_pulse | output | 6 | Per-address write pulses |

## Verification
The status field is driven with random values of both signs. This shows whether the top bits are sign-extended or zero-filled. Event bursts of random length are followed by clearing reads, with an extra case where an event lands on the clearing cycle; together these separate a counter that drops events, clears late, or fails to clear. The wide count is changed between the low-word and high-word reads, so a design that returns live upper bits is caught. Writes to every read-only and unmapped address, and reads of write-only and unmapped addresses, show whether any side effect leaks outside its own address.

// File: rtl/mmr_pkg.sv
package mmr_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int NUM_MAPPED = 6;
    localparam int STAT_W     = 12;
    localparam int WIDE_W     = 64;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RW,
        ACC_RO,
        ACC_WO,
        ACC_CLR_RD,
        ACC_STROBE_WR
    } acc_mode_e;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd1;
    localparam logic [ADDR_W-1:0] A_EVT     = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMD     = 3'd3;
    localparam logic [ADDR_W-1:0] A_WIDE_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_WIDE_HI = 3'd5;

    typedef struct packed {
        logic [NUM_MAPPED-1:0] rd;
        logic [NUM_MAPPED-1:0] wr;
    } hit_t;

    function automatic acc_mode_e mode_of(input logic [ADDR_W-1:0] a);
        case (a)
            A_CTRL:    return ACC_RW;
            A_STAT:    return ACC_RO;
            A_EVT:     return ACC_CLR_RD;
            A_CMD:     return ACC_STROBE_WR;
            A_WIDE_LO: return ACC_RO;
            A_WIDE_HI: return ACC_RO;
            default:   return ACC_NONE;
        endcase
    endfunction

    function automatic logic is_readable(input acc_mode_e m);
        return (m == ACC_RW) || (m == ACC_RO) || (m == ACC_CLR_RD);
    endfunction

    function automatic logic is_writable(input acc_mode_e m);
        return (m == ACC_RW) || (m == ACC_WO) || (m == ACC_STROBE_WR);
    endfunction

    function automatic logic [DATA_W-1:0] sext_stat(input logic [STAT_W-1:0] v);
        return {{(DATA_W-STAT_W){v[STAT_W-1]}}, v};
    endfunction

endpackage

// File: rtl/mmr_decode.sv
module mmr_decode
    import mmr_pkg::*;
(
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output hit_t              hit
);

    for (genvar i = 0; i < NUM_MAPPED; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        localparam logic CAN_RD = is_readable(mode_of(IDX));
        localparam logic CAN_WR = is_writable(mode_of(IDX));
        assign hit.rd[i] = CAN_RD && bus_rd && (bus_addr == IDX);
        assign hit.wr[i] = CAN_WR && bus_wr && (bus_addr == IDX);
    end

endmodule

// File: rtl/mmr_event_ctr.sv
module mmr_event_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (clr)
            count <= evt ? CNT_W'(1) : '0;
        else if (evt)
            count <= count + CNT_W'(1);
    end

endmodule

// File: rtl/mmr_wide_snap.sv
module mmr_wide_snap #(
    parameter int FIELD_W = 64,
    parameter int WORD_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] value_in,
    input  logic               capture,
    output logic [WORD_W-1:0]  lo_word,
    output logic [WORD_W-1:0]  hi_word
);

    localparam int HI_W = FIELD_W - WORD_W;

    logic [HI_W-1:0] held_hi;

    always_ff @(posedge clk) begin
        if (rst)
            held_hi <= '0;
        else if (capture)
            held_hi <= value_in[FIELD_W-1:WORD_W];
    end

    assign lo_word = value_in[WORD_W-1:0];
    assign hi_word = WORD_W'(held_hi);

endmodule

// File: rtl/mmr_field_regs.sv
module mmr_field_regs
    import mmr_pkg::*;
#(
    parameter logic [31:0] CTRL_DEFAULT = 32'h0000_0001,
    parameter int          EVT_W        = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    output logic [31:0] ctrl_out,
    input  logic [11:0] stat_in,
    input  logic        evt_in,
    output logic        cmd_pulse,
    output logic [31:0] cmd_data,
    input  logic [63:0] wide_cnt_in,
    output logic [5:0]  addr_rd_pulse,
    output logic [5:0]  addr_wr_pulse
);

    hit_t              hit;
    logic [EVT_W-1:0]  evt_count;
    logic [DATA_W-1:0] wide_lo;
    logic [DATA_W-1:0] wide_hi;
    logic [DATA_W-1:0] rd_word;

    mmr_decode u_dec (
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    mmr_event_ctr #(.CNT_W(EVT_W)) u_evt (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_in),
        .clr   (hit.rd[A_EVT]),
        .count (evt_count)
    );

    mmr_wide_snap #(.FIELD_W(WIDE_W), .WORD_W(DATA_W)) u_wide (
        .clk      (clk),
        .rst      (rst),
        .value_in (wide_cnt_in),
        .capture  (hit.rd[A_WIDE_LO]),
        .lo_word  (wide_lo),
        .hi_word  (wide_hi)
    );

    always_comb begin
        case (bus_addr)
            A_CTRL:    rd_word = ctrl_out;
            A_STAT:    rd_word = sext_stat(stat_in);
            A_EVT:     rd_word = DATA_W'(evt_count);
            A_WIDE_LO: rd_word = wide_lo;
            A_WIDE_HI: rd_word = wide_hi;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_out      <= CTRL_DEFAULT;
            cmd_pulse     <= 1'b0;
            cmd_data      <= '0;
            bus_rdata     <= '0;
            bus_rvalid    <= 1'b0;
            addr_rd_pulse <= '0;
            addr_wr_pulse <= '0;
        end else begin
            if (hit.wr[A_CTRL])
                ctrl_out <= bus_wdata;
            cmd_pulse <= hit.wr[A_CMD];
            if (hit.wr[A_CMD])
                cmd_data <= bus_wdata;
            bus_rvalid <= bus_rd;
            if (bus_rd)
                bus_rdata <= rd_word;
            addr_rd_pulse <= hit.rd;
            addr_wr_pulse <= hit.wr;
        end
    end

endmodule

// File: rtl/mmr_checker.sv
module mmr_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic        bus_rvalid,
    input logic [31:0] ctrl_out,
    input logic [11:0] stat_in,
    input logic        cmd_pulse,
    input logic [31:0] cmd_data,
    input logic [63:0] wide_cnt_in,
    input logic [5:0]  addr_rd_pulse,
    input logic [5:0]  addr_wr_pulse
);

    a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    a_r2_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !bus_rvalid);

    a_r3_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd0) |=> (ctrl_out == $past(bus_wdata)));

    a_r4_status_sext: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd1) |=>
        (bus_rdata == {{20{$past(stat_in[11])}}, $past(stat_in)}));

    a_r5_ro_write_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != 3'd0) |=> $stable(ctrl_out));

    a_r6_zero_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == 3'd3 || bus_addr == 3'd6 || bus_addr == 3'd7)) |=>
        (bus_rdata == 32'd0));

    a_r7_counter_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd2) |=> (bus_rdata[31:16] == 16'd0));

    a_r9_cmd_strobe: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd3) |=> (cmd_pulse && cmd_data == $past(bus_wdata)));

    a_r9_no_extra_strobe: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 3'd3) |=> !cmd_pulse);

    a_r10_low_word_live: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd4) |=> (bus_rdata == $past(wide_cnt_in[31:0])));

    a_r11_pulses_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(addr_rd_pulse) && $onehot0(addr_wr_pulse));

    a_r11_no_pulse_idle: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !bus_wr) |=> (addr_rd_pulse == 6'd0 && addr_wr_pulse == 6'd0));

endmodule

bind mmr_field_regs mmr_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .ctrl_out      (ctrl_out),
    .stat_in       (stat_in),
    .cmd_pulse     (cmd_pulse),
    .cmd_data      (cmd_data),
    .wide_cnt_in   (wide_cnt_in),
    .addr_rd_pulse (addr_rd_pulse),
    .addr_wr_pulse (addr_wr_pulse)
);

// File: tb/sim_mmr_field_regs.sv
`timescale 1ns/1ps
module sim_mmr_field_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] ctrl_out;
    logic [11:0] stat_in = '0;
    logic        evt_in = 1'b0;
    logic        cmd_pulse;
    logic [31:0] cmd_data;
    logic [63:0] wide_cnt_in = '0;
    logic [5:0]  addr_rd_pulse;
    logic [5:0]  addr_wr_pulse;

    int errors = 0;
    int checks = 0;
    logic [15:0] evt_model = '0;
    logic [31:0] ctrl_model = 32'h1;
    logic [31:0] hi_model = '0;
    logic [5:0]  seen_rdp;
    logic [5:0]  seen_wrp;
    logic        seen_rvalid;
    logic        seen_pulse;
    logic [31:0] seen_cdata;

    always #4 clk = ~clk;

    mmr_field_regs u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ctrl_out(ctrl_out), .stat_in(stat_in),
        .evt_in(evt_in), .cmd_pulse(cmd_pulse), .cmd_data(cmd_data),
        .wide_cnt_in(wide_cnt_in), .addr_rd_pulse(addr_rd_pulse),
        .addr_wr_pulse(addr_wr_pulse)
    );

    function automatic logic [31:0] exp_sext(input logic [11:0] v);
        return {{20{v[11]}}, v};
    endfunction

    function automatic logic [5:0] exp_rd_pulse(input logic [2:0] a);
        return (a == 0 || a == 1 || a == 2 || a == 4 || a == 5) ? 6'(1 << a) : 6'd0;
    endfunction

    function automatic logic [5:0] exp_wr_pulse(input logic [2:0] a);
        return (a == 0 || a == 3) ? 6'(1 << a) : 6'd0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        seen_rvalid = bus_rvalid;
        seen_rdp = addr_rd_pulse;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        seen_wrp = addr_wr_pulse;
        seen_pulse = cmd_pulse;
        seen_cdata = cmd_data;
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            evt_in = 1'b1;
        end
        @(negedge clk);
        evt_in = 1'b0;
        evt_model = evt_model + 16'(n);
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20931));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 ctrl", 64'(ctrl_out), 64'h1);
        check("R1 cmd_pulse", 64'(cmd_pulse), 0);
        check("R1 rvalid", 64'(bus_rvalid), 0);
        bus_read(3'd2, d);
        check("R1 evt", 64'(d), 0);
        bus_read(3'd5, d);
        check("R1 hi", 64'(d), 0);

        // R2: rvalid one cycle only
        bus_read(3'd0, d);
        check("R2 rvalid", 64'(seen_rvalid), 1);
        check("R3 ctrl read", 64'(d), 64'h1);
        @(negedge clk);
        check("R2 rvalid low", 64'(bus_rvalid), 0);

        // R9: command strobe
        bus_write(3'd3, 32'hC0DE_0042);
        check("R9 pulse", 64'(seen_pulse), 1);
        check("R9 data", 64'(seen_cdata), 64'hC0DE_0042);
        check("R11 wr pulse cmd", 64'(seen_wrp), 64'(exp_wr_pulse(3'd3)));
        @(negedge clk);
        check("R9 pulse once", 64'(cmd_pulse), 0);

        // R6: write-only and unmapped read zero
        for (int a = 6; a < 9; a++) begin
            logic [2:0] aa;
            aa = (a == 8) ? 3'd3 : 3'(a);
            bus_read(aa, d);
            check("R6 zero", 64'(d), 0);
            check("R11 rd pulse", 64'(seen_rdp), 64'(exp_rd_pulse(aa)));
        end

        // R5: writes to read-only/unmapped addresses ignored
        events(3);
        wide_cnt_in = 64'h1111_2222_3333_4444;
        bus_read(3'd4, d);
        hi_model = 32'h1111_2222;
        wide_cnt_in = 64'h5555_6666_7777_8888;
        for (int a = 1; a < 8; a++) begin
            if (a == 3 || a == 0) continue;
            bus_write(3'(a), 32'hFFFF_FFFF);
            check("R5 ctrl kept", 64'(ctrl_out), 64'(ctrl_model));
            check("R5 no wr pulse", 64'(seen_wrp), 0);
            check("R5 no strobe", 64'(seen_pulse), 0);
        end
        bus_read(3'd5, d);
        check("R5 R10 hi kept", 64'(d), 64'(hi_model));
        bus_read(3'd2, d);
        check("R5 R7 evt kept", 64'(d), 64'(evt_model));
        evt_model = 0;

        // R8: event coincident with clearing read
        events(4);
        @(negedge clk);
        bus_addr = 3'd2;
        bus_rd = 1'b1;
        evt_in = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        evt_in = 1'b0;
        check("R8 old count", 64'(bus_rdata), 64'(evt_model));
        evt_model = 16'd1;
        bus_read(3'd2, d);
        check("R8 becomes one", 64'(d), 1);
        evt_model = 0;

        // random mix
        for (int it = 0; it < 60; it++) begin
            int op;
            op = int'($urandom % 4);
            case (op)
                0: begin
                    ctrl_model = $urandom;
                    bus_write(3'd0, ctrl_model);
                    check("R3 ctrl_out", 64'(ctrl_out), 64'(ctrl_model));
                    check("R11 wr pulse ctrl", 64'(seen_wrp), 64'(exp_wr_pulse(3'd0)));
                    bus_read(3'd0, d);
                    check("R3 readback", 64'(d), 64'(ctrl_model));
                end
                1: begin
                    logic [11:0] s;
                    s = 12'($urandom);
                    stat_in = s;
                    bus_read(3'd1, d);
                    check("R4 sext", 64'(d), 64'(exp_sext(s)));
                    check("R11 rd pulse stat", 64'(seen_rdp), 64'(exp_rd_pulse(3'd1)));
                end
                2: begin
                    events(int'($urandom % 6));
                    bus_read(3'd2, d);
                    check("R7 count", 64'(d), 64'(evt_model));
                    evt_model = 0;
                end
                default: begin
                    logic [63:0] w;
                    w = {$urandom, $urandom};
                    wide_cnt_in = w;
                    bus_read(3'd4, d);
                    check("R10 lo", 64'(d), 64'(w[31:0]));
                    wide_cnt_in = {$urandom, $urandom};
                    bus_read(3'd5, d);
                    check("R10 hi frozen", 64'(d), 64'(w[63:32]));
                end
            endcase
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule